// File: doc/BRIEF.md
# SDRAM Command Issuer Under Software Control

This block sits between a register/bus slave and one SDR-SDRAM device. Software brings the memory up by choosing a command through a 3-bit mode input and then making a write access anywhere in the memory window. Each accepted write drives exactly one command on the SDRAM control pins: no-operation, precharge of all banks, auto-refresh, mode-register load or extended mode-register load. The bank pins are always taken from the access address. For the two register loads, the address pins carry the row field of the access address.

After reset, the block holds its bus ready low for a fixed number of clock cycles before it accepts anything. The SDRAM clock enable stays off until the first no-operation command has been driven. After a precharge or a refresh, ready stays low for a programmed number of cycles.

In normal mode (code 0), accepted accesses are handed to a downstream controller through a start pulse and a done input. A programmable refresh timer then requests a periodic auto-refresh. That refresh waits until any access in flight has completed.

Top module: `sdr_cmd_issuer`

## Requirements
- R1: While reset is asserted, `acc_ready` is 0, `sd_clk_en` is 0 and the command pins `{sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}` read 1111 (deselect).
- R2: After reset is released, `acc_ready` stays 0 for exactly PWRUP_CYC clock edges, and the command pins stay at 1111 during that time.
- R3: A write accepted (`acc_valid` and `acc_ready` high at a clock edge) with mode 1, 2 or 4 drives 0111 (NOP), 0010 (precharge) or 0001 (auto-refresh) on the command pins in the following cycle. Every cycle with no command reads 1111. Each of the eight refreshes of the bring-up needs its own write.
- R4: `sd_clk_en` rises in the same cycle as the first NOP command and never falls again until reset.
- R5: A precharge drives address pin 10 high and all other address pins low. `sd_ba` takes byte-address bits [23:22] (bit 22 is bank bit 0).
- R6: A write accepted with mode 3 (mode-register load) or mode 5 (extended mode-register load) drives 0000. `sd_ba` takes address bits [23:22] and `sd_a` takes address bits [21:10]. An extended load at offset 0x00800000 therefore gives `sd_ba` = 10.
- R7: After a precharge is accepted, `acc_ready` stays 0 for exactly `trp_cycles` cycles. After an auto-refresh is accepted, it stays 0 for exactly `trc_cycles` cycles.
- R8: A read accepted while the mode is nonzero drives no command. The pins stay at 1111.
- R9: In mode 0, an accepted access gives a one-cycle `norm_start` pulse in the next cycle and drives no command. `acc_ready` then stays 0 until `norm_done` is seen.
- R10: In mode 0 with no traffic, consecutive auto-refresh commands are exactly `refresh_count` cycles apart (`refresh_count` of 2 or more, `trc_cycles` below it).
- R11: If the refresh timer expires during a normal access, no refresh is driven while the access is open. `acc_ready` stays 0 while the refresh is pending, and the refresh command appears in the second cycle after the edge that sees `norm_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Bus access request |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access within the memory window |
| acc_ready | output | 1 | Access accepted when high together with acc_valid |
| mode_sel | input | 3 | Command code: 0 normal, 1 NOP, 2 precharge all, 3 mode load, 4 auto-refresh, 5 extended mode load |
| refresh_count | input | RCNT_W | Refresh period in clock cycles |
| trp_cycles | input | TIM_W | Hold-off after precharge |
| trc_cycles | input | TIM_W | Hold-off after auto-refresh |
| norm_start | output | 1 | One-cycle start of a normal access |
| norm_done | input | 1 | Downstream controller finished the normal access |
| sd_clk_en | output | 1 | Enable for the SDRAM clock gate |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | ROW_W | Address pins |

## Verification
The assertions assume that `mode_sel`, `trp_cycles` and `trc_cycles` are stable around the edge that accepts a command. They also assume that `norm_done` arrives only while a normal access is open, and that `refresh_count` is at least 2 and larger than `trc_cycles`. The bench changes inputs only at falling edges and switches the mode only between accesses. It raises `norm_done` once per started access, and it programs a refresh period of 60 with hold-offs of 3 and 5 cycles.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

   typedef enum logic [2:0] {
      MODE_NORMAL = 3'd0,
      MODE_NOP    = 3'd1,
      MODE_PALL   = 3'd2,
      MODE_LMR    = 3'd3,
      MODE_CBR    = 3'd4,
      MODE_XLMR   = 3'd5
   } mode_e;

   // command pins packed as {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] sd_cmd_t;

   localparam sd_cmd_t CMD_IDLE = 4'b1111;
   localparam sd_cmd_t CMD_NOP  = 4'b0111;
   localparam sd_cmd_t CMD_PRE  = 4'b0010;
   localparam sd_cmd_t CMD_REF  = 4'b0001;
   localparam sd_cmd_t CMD_LMR  = 4'b0000;

   localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/sdr_downcount.sv
module sdr_downcount #(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= RST_VAL;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
   import sdr_cmd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ROW_W   = 12,
   parameter int ROW_LSB = 10,
   parameter int BA_LSB  = 22,
   parameter int TIM_W   = 6,
   parameter bit EMRS_EN = 1'b1
) (
   input  logic              issue_init,
   input  logic              ref_issue,
   input  mode_e             mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TIM_W-1:0]  trp,
   input  logic [TIM_W-1:0]  trc,
   output sd_cmd_t           cmd,
   output logic [1:0]        ba,
   output logic [ROW_W-1:0]  a,
   output logic              hold_load,
   output logic [TIM_W-1:0]  hold_val
);

   logic [ROW_W-1:0] row_f;
   logic [1:0]       ba_f;
   logic             xlmr_ok;

   assign row_f = addr[ROW_LSB +: ROW_W];
   assign ba_f  = addr[BA_LSB +: 2];

   generate
      if (EMRS_EN) begin : g_xlmr
         assign xlmr_ok = 1'b1;
      end else begin : g_no_xlmr
         assign xlmr_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      cmd       = CMD_IDLE;
      ba        = '0;
      a         = '0;
      hold_load = 1'b0;
      hold_val  = '0;
      if (ref_issue) begin
         cmd       = CMD_REF;
         hold_load = 1'b1;
         hold_val  = trc;
      end else if (issue_init) begin
         case (mode)
            MODE_NOP: begin
               cmd = CMD_NOP;
               ba  = ba_f;
            end
            MODE_PALL: begin
               cmd            = CMD_PRE;
               ba             = ba_f;
               a[PRE_ALL_BIT] = 1'b1;
               hold_load      = 1'b1;
               hold_val       = trp;
            end
            MODE_CBR: begin
               cmd       = CMD_REF;
               ba        = ba_f;
               hold_load = 1'b1;
               hold_val  = trc;
            end
            MODE_LMR: begin
               cmd = CMD_LMR;
               ba  = ba_f;
               a   = row_f;
            end
            MODE_XLMR: begin
               if (xlmr_ok) begin
                  cmd = CMD_LMR;
                  ba  = ba_f;
                  a   = row_f;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sdr_cmd_issuer.sv
module sdr_cmd_issuer
   import sdr_cmd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BYTE_SHIFT = 1,
   parameter int COL_W      = 9,
   parameter int ROW_W      = 12,
   parameter int TIM_W      = 6,
   parameter int RCNT_W     = 16,
   parameter int PWRUP_CYC  = 20000,
   parameter bit EMRS_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              acc_ready,
   input  logic [2:0]        mode_sel,
   input  logic [RCNT_W-1:0] refresh_count,
   input  logic [TIM_W-1:0]  trp_cycles,
   input  logic [TIM_W-1:0]  trc_cycles,
   output logic              norm_start,
   input  logic              norm_done,
   output logic              sd_clk_en,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [1:0]        sd_ba,
   output logic [ROW_W-1:0]  sd_a
);

   localparam int ROW_LSB = BYTE_SHIFT + COL_W;
   localparam int BA_LSB  = ROW_LSB + ROW_W;
   localparam int PWR_W   = $clog2(PWRUP_CYC + 1);

   initial begin
      if (ROW_W <= PRE_ALL_BIT) $error("ROW_W too small for the precharge-all bit");
      if (BA_LSB + 2 > ADDR_W)  $error("bank field lies outside the address");
      if (PWRUP_CYC < 1)        $error("PWRUP_CYC must be at least 1");
      if (TIM_W < 1 || RCNT_W < 2) $error("timer widths too small");
   end

   mode_e             mode;
   logic              normal;
   logic              pwr_done, hold_idle, tmr_zero;
   logic              in_acc_q, clk_en_q, start_q;
   logic              ref_pend, free, accept, ref_issue, issue_init, norm_acc;
   sd_cmd_t           cmd_d, cmd_q;
   logic [1:0]        ba_d, ba_q;
   logic [ROW_W-1:0]  a_d, a_q;
   logic              hold_load;
   logic [TIM_W-1:0]  hold_val;

   assign mode       = mode_e'(mode_sel);
   assign normal     = (mode_sel == 3'd0);
   assign ref_pend   = normal && tmr_zero && clk_en_q;
   assign free       = pwr_done && hold_idle && !in_acc_q;
   assign acc_ready  = free && !ref_pend;
   assign accept     = acc_valid && acc_ready;
   assign ref_issue  = free && ref_pend;
   assign issue_init = accept && acc_write && !normal;
   assign norm_acc   = accept && normal;

   // power-up wait before the first command
   sdr_downcount #(.W(PWR_W), .RST_VAL(PWR_W'(PWRUP_CYC))) pwr_i (
      .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .zero(pwr_done)
   );

   // hold-off after precharge or refresh
   sdr_downcount #(.W(TIM_W), .RST_VAL('0)) hold_i (
      .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(hold_val),
      .zero(hold_idle)
   );

   // refresh interval timer, parked while an init mode is selected
   sdr_downcount #(.W(RCNT_W), .RST_VAL('0)) rtmr_i (
      .clk(clk), .rst_n(rst_n), .load(!normal || ref_issue),
      .load_val(refresh_count - 1'b1), .zero(tmr_zero)
   );

   sdr_cmd_encode #(
      .ADDR_W(ADDR_W), .ROW_W(ROW_W), .ROW_LSB(ROW_LSB), .BA_LSB(BA_LSB),
      .TIM_W(TIM_W), .EMRS_EN(EMRS_EN)
   ) enc_i (
      .issue_init(issue_init), .ref_issue(ref_issue), .mode(mode),
      .addr(acc_addr), .trp(trp_cycles), .trc(trc_cycles),
      .cmd(cmd_d), .ba(ba_d), .a(a_d),
      .hold_load(hold_load), .hold_val(hold_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= CMD_IDLE;
         ba_q     <= '0;
         a_q      <= '0;
         clk_en_q <= 1'b0;
         start_q  <= 1'b0;
         in_acc_q <= 1'b0;
      end else begin
         cmd_q    <= cmd_d;
         ba_q     <= ba_d;
         a_q      <= a_d;
         clk_en_q <= clk_en_q || (cmd_d == CMD_NOP);
         start_q  <= norm_acc;
         if (norm_acc)       in_acc_q <= 1'b1;
         else if (norm_done) in_acc_q <= 1'b0;
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba      = ba_q;
   assign sd_a       = a_q;
   assign sd_clk_en  = clk_en_q;
   assign norm_start = start_q;

endmodule

// File: rtl/sdr_cmd_issuer_chk.sv
module sdr_cmd_issuer_chk #(
   parameter int ADDR_W    = 32,
   parameter int ROW_W     = 12,
   parameter int BA_LSB    = 22,
   parameter int TIM_W     = 6,
   parameter int PWRUP_CYC = 20000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_ready,
   input logic [2:0]        mode_sel,
   input logic [TIM_W-1:0]  trp_cycles,
   input logic [TIM_W-1:0]  trc_cycles,
   input logic              norm_start,
   input logic              norm_done,
   input logic              sd_clk_en,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [1:0]        sd_ba,
   input logic [ROW_W-1:0]  sd_a
);

   logic [3:0]       cmd;
   logic             acc_ok;
   int unsigned      pw_cnt;
   logic [TIM_W-1:0] hold_cnt;
   logic             open_acc;

   assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign acc_ok = acc_valid && acc_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pw_cnt <= 0;
      else if (pw_cnt < PWRUP_CYC) pw_cnt <= pw_cnt + 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_cnt <= '0;
      else if (acc_ok && acc_write && mode_sel == 3'd2) hold_cnt <= trp_cycles;
      else if (acc_ok && acc_write && mode_sel == 3'd4) hold_cnt <= trc_cycles;
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_acc <= 1'b0;
      else if (acc_ok && mode_sel == 3'd0) open_acc <= 1'b1;
      else if (norm_done) open_acc <= 1'b0;
   end

   AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_cnt < PWRUP_CYC) |-> (!acc_ready && cmd == 4'b1111)); // R2

   AST_CLK_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sd_clk_en |=> sd_clk_en); // R4

   AST_CLK_EN_WITH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_clk_en) |-> (cmd == 4'b0111)); // R4

   AST_PRE_ALL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0010) |-> sd_a[10]); // R5

   AST_LMR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && acc_write && mode_sel == 3'd3) |=>
      (cmd == 4'b0000 && sd_ba == $past(acc_addr[BA_LSB +: 2]))); // R6

   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cnt != '0) |-> !acc_ready); // R7

   AST_READ_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && !acc_write && mode_sel != 3'd0) |=> (cmd == 4'b1111)); // R8

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      norm_start |=> !norm_start); // R9

   AST_NO_REF_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      open_acc |-> (cmd != 4'b0001)); // R11

endmodule

bind sdr_cmd_issuer sdr_cmd_issuer_chk #(
   .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BA_LSB(BA_LSB), .TIM_W(TIM_W),
   .PWRUP_CYC(PWRUP_CYC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .acc_ready(acc_ready), .mode_sel(mode_sel),
   .trp_cycles(trp_cycles), .trc_cycles(trc_cycles),
   .norm_start(norm_start), .norm_done(norm_done), .sd_clk_en(sd_clk_en),
   .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
   .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a)
);

// File: tb/sdr_cmd_issuer_tb_top.sv
module sdr_cmd_issuer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 32;
   localparam int ROW_W      = 12;
   localparam int TIM_W      = 6;
   localparam int RCNT_W     = 16;
   localparam int PWRUP      = 40;
   localparam int TRP        = 3;
   localparam int TRC        = 5;
   localparam int RPER       = 60;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic              acc_ready;
   logic [2:0]        mode_sel = 3'd1;
   logic [RCNT_W-1:0] refresh_count = RCNT_W'(RPER);
   logic [TIM_W-1:0]  trp_cycles = TIM_W'(TRP);
   logic [TIM_W-1:0]  trc_cycles = TIM_W'(TRC);
   logic              norm_start;
   logic              norm_done = 1'b0;
   logic              sd_clk_en, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]        sd_ba;
   logic [ROW_W-1:0]  sd_a;
   logic [3:0]        cmd_obs;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ref_cnt = 0;
   int ref_last = 0;
   int ref_prev = 0;
   bit done_flag = 0;

   assign cmd_obs = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   sdr_cmd_issuer #(
      .ADDR_W(ADDR_W), .ROW_W(ROW_W), .TIM_W(TIM_W), .RCNT_W(RCNT_W),
      .PWRUP_CYC(PWRUP)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_ready(acc_ready), .mode_sel(mode_sel),
      .refresh_count(refresh_count), .trp_cycles(trp_cycles),
      .trc_cycles(trc_cycles), .norm_start(norm_start), .norm_done(norm_done),
      .sd_clk_en(sd_clk_en), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && cmd_obs == 4'b0001) begin
         ref_prev = ref_last;
         ref_last = cyc;
         ref_cnt  = ref_cnt + 1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // drive one access and return at the falling edge after the accepting edge
   task automatic access(input logic [2:0] m, input logic w, input logic [ADDR_W-1:0] ad);
      int n = 0;
      @(negedge clk);
      mode_sel  = m;
      acc_write = w;
      acc_addr  = ad;
      acc_valid = 1'b1;
      while (!acc_ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // count falling edges with ready low, starting at the current one
   task automatic count_hold(output int n);
      n = 0;
      while (!acc_ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_powerup();
      int n = 0;
      bit quiet = 1;
      @(negedge clk);
      chk("R1", "ready in reset", acc_ready, 0);
      chk("R1", "clk_en in reset", sd_clk_en, 0);
      chk("R1", "cmd in reset", cmd_obs, 4'b1111);
      rst_n = 1'b1;
      while (n < 1000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (cmd_obs != 4'b1111) quiet = 0;
         if (acc_ready) break;
      end
      chk("R2", "power-up wait length", n, PWRUP);
      chk("R2", "pins idle during wait", quiet, 1);
   endtask

   task automatic t_nop();
      @(negedge clk);
      chk("R4", "clk_en before NOP", sd_clk_en, 0);
      access(3'd1, 1'b1, 32'h0000_1234);
      chk("R3", "NOP code", cmd_obs, 4'b0111);
      chk("R4", "clk_en with NOP", sd_clk_en, 1);
      @(negedge clk);
      chk("R3", "idle after NOP", cmd_obs, 4'b1111);
      chk("R4", "clk_en stays on", sd_clk_en, 1);
   endtask

   task automatic t_read_ignored();
      access(3'd2, 1'b0, 32'h0040_0000);
      chk("R8", "read in init mode gives no command", cmd_obs, 4'b1111);
      chk("R8", "no hold-off after read", acc_ready, 1);
   endtask

   task automatic t_precharge();
      int n;
      access(3'd2, 1'b1, 32'h0040_0000);
      chk("R3", "precharge code", cmd_obs, 4'b0010);
      chk("R5", "precharge address pins", sd_a, 12'h400);
      chk("R5", "precharge bank from addr[23:22]", sd_ba, 2'b01);
      count_hold(n);
      chk("R7", "hold-off after precharge", n, TRP);
   endtask

   task automatic t_refresh8();
      int n;
      for (int i = 0; i < 8; i++) begin
         access(3'd4, 1'b1, 32'h0000_0000);
         chk("R3", "auto-refresh code", cmd_obs, 4'b0001);
         count_hold(n);
         chk("R7", "hold-off after refresh", n, TRC);
      end
   endtask

   task automatic t_mode_loads();
      access(3'd3, 1'b1, 32'h0000_0000 | (32'h033 << 10));
      chk("R6", "mode load code", cmd_obs, 4'b0000);
      chk("R6", "mode load bank", sd_ba, 2'b00);
      chk("R6", "mode load value", sd_a, 12'h033);
      access(3'd5, 1'b1, 32'h0080_0000 | (32'h020 << 10));
      chk("R6", "extended load code", cmd_obs, 4'b0000);
      chk("R6", "extended load bank", sd_ba, 2'b10);
      chk("R6", "extended load value", sd_a, 12'h020);
   endtask

   task automatic t_normal();
      access(3'd0, 1'b1, 32'h0012_3456);
      chk("R9", "start pulse", norm_start, 1);
      chk("R9", "no command for normal access", cmd_obs, 4'b1111);
      chk("R9", "ready low while open", acc_ready, 0);
      @(negedge clk);
      chk("R9", "start pulse ends", norm_start, 0);
      chk("R9", "still busy without done", acc_ready, 0);
      norm_done = 1'b1;
      @(negedge clk);
      norm_done = 1'b0;
      chk("R9", "ready after done", acc_ready, 1);
   endtask

   task automatic t_period();
      int base = ref_cnt;
      int n = 0;
      while (ref_cnt < base + 2 && n < 1000) begin
         n++;
         @(negedge clk);
      end
      chk("R10", "two refreshes seen", ref_cnt - base >= 2, 1);
      chk("R10", "refresh spacing", ref_last - ref_prev, RPER);
   endtask

   task automatic t_defer();
      int base;
      int n = 0;
      base = ref_cnt;
      while (ref_cnt == base && n < 1000) begin
         n++;
         @(negedge clk);
      end
      access(3'd0, 1'b0, 32'h0000_0100);
      chk("R9", "start pulse before deferral", norm_start, 1);
      base = ref_cnt;
      repeat (RPER + 20) @(negedge clk);
      chk("R11", "no refresh while access open", ref_cnt - base, 0);
      chk("R11", "ready low with refresh pending", acc_ready, 0);
      norm_done = 1'b1;
      @(negedge clk);
      norm_done = 1'b0;
      chk("R11", "idle in first cycle after done", cmd_obs, 4'b1111);
      chk("R11", "ready low while refresh pending", acc_ready, 0);
      @(negedge clk);
      chk("R11", "deferred refresh issued", cmd_obs, 4'b0001);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL all: watchdog expired, actual running expected finished");
      finish_run();
   end

   initial begin
      t_reset_powerup();
      t_nop();
      t_read_ignored();
      t_precharge();
      t_refresh8();
      t_mode_loads();
      t_normal();
      t_period();
      t_defer();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule